// File: doc/BRIEF.md
# Mesh Network Interface Packet Wrapper

This block sits between a processing element and the local port of its mesh router. On the outbound path the processing element supplies a destination mesh coordinate (x,y) and a stream of payload words, the last of them marked. The wrapper first emits one header flit that carries the coordinate. Each payload word then follows as one data flit, and the final data flit is marked as the tail. Every flit carries two kind bits above a body field.

On the inbound path the wrapper takes flits from the router's local output. It discards header flits and hands only the body of each data flit to the processing element, with an end-of-message flag raised on the word taken from a tail flit.

Every side uses a valid/ready handshake. A stall on either far side is pushed back to the near side without losing a word and without sending any word twice.

Top module: `ni_wrapper`

## Requirements
- R1: After reset, rt_out_valid and pe_rx_valid are low, pe_tx_ready is low, and rt_in_ready is high.
- R2: A flit is {kind[1:0], body[DATA_W-1:0]}. The kind values are 2'b10 for a header, 2'b00 for a data flit and 2'b01 for a tail data flit. A header body holds x in bits [COORD_W-1:0] and y in bits [2*COORD_W-1:COORD_W], and its upper bits are zero.
- R3: Each packet begins with exactly one header flit. The first payload word is not accepted before that header has been loaded, and after a word marked last the next word waits for a new header.
- R4: Each accepted payload word becomes exactly one data flit, in order and with its value unchanged. The word marked last becomes a tail flit.
- R5: While rt_out_valid is high and rt_out_ready is low, rt_out_valid and rt_out_flit hold steady in the next cycle.
- R6: A flit whose top kind bit is 1 (a header) is consumed and never reaches pe_rx_data.
- R7: Data flits reach the processing element in arrival order with their body unchanged. pe_rx_last is high exactly for the word taken from a tail flit.
- R8: While pe_rx_valid is high and pe_rx_ready is low, the output word holds steady and rt_in_ready is low.
- R9: The header of each packet carries the coordinate presented with that packet, so consecutive packets to different nodes get different headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_tx_valid | input | 1 | Processing element offers a payload word |
| pe_tx_ready | output | 1 | Wrapper takes the payload word |
| pe_tx_data | input | DATA_W | Outbound payload word |
| pe_tx_last | input | 1 | Word is the last of its message |
| pe_tx_dst_x | input | COORD_W | Destination column |
| pe_tx_dst_y | input | COORD_W | Destination row |
| rt_out_valid | output | 1 | Flit offered to router local input |
| rt_out_ready | input | 1 | Router accepts the flit |
| rt_out_flit | output | DATA_W+2 | Outbound flit |
| rt_in_valid | input | 1 | Router offers a flit from its local output |
| rt_in_ready | output | 1 | Wrapper takes the flit |
| rt_in_flit | input | DATA_W+2 | Inbound flit |
| pe_rx_valid | output | 1 | Payload word offered to processing element |
| pe_rx_ready | input | 1 | Processing element takes the word |
| pe_rx_data | output | DATA_W | Inbound payload word |
| pe_rx_last | output | 1 | Word ends a message |

## Verification
The hardest case to reach is a full output register on either side that meets a stall while a new word is already waiting behind it. Reaching it takes backpressure that changes from cycle to cycle at the moment a header flit is being loaded or a tail flit is leaving. The bench drives the router-ready and processing-element-ready lines from a free-running LFSR while packets of several lengths are streamed. A separate scenario holds the receive side stalled with a second flit queued and then inspects both handshakes.

// File: rtl/ni_pkg.sv
package ni_pkg;
    localparam logic [1:0] KIND_HEAD = 2'b10;
    localparam logic [1:0] KIND_BODY = 2'b00;
    localparam logic [1:0] KIND_TAIL = 2'b01;

    typedef enum logic {TX_HEAD, TX_BODY} tx_phase_e;
endpackage

// File: rtl/ni_tx_packer.sv
module ni_tx_packer
    import ni_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pe_tx_valid,
    output logic               pe_tx_ready,
    input  logic [DATA_W-1:0]  pe_tx_data,
    input  logic               pe_tx_last,
    input  logic [COORD_W-1:0] pe_tx_dst_x,
    input  logic [COORD_W-1:0] pe_tx_dst_y,
    output logic               rt_out_valid,
    input  logic               rt_out_ready,
    output logic [DATA_W+1:0]  rt_out_flit
);
    localparam int FLIT_W = DATA_W + 2;
    localparam int PAD_W  = DATA_W - 2 * COORD_W;

    typedef struct packed {
        tx_phase_e         phase;
        logic              ovalid;
        logic [FLIT_W-1:0] oflit;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      can_load;

    always_comb begin
        st_d        = st_q;
        can_load    = !st_q.ovalid || rt_out_ready;
        pe_tx_ready = (st_q.phase == TX_BODY) && can_load;
        if (st_q.ovalid && rt_out_ready) begin
            st_d.ovalid = 1'b0;
        end
        if (st_q.phase == TX_HEAD) begin
            if (pe_tx_valid && can_load) begin
                st_d.ovalid = 1'b1;
                st_d.oflit  = {KIND_HEAD, {PAD_W{1'b0}}, pe_tx_dst_y, pe_tx_dst_x};
                st_d.phase  = TX_BODY;
            end
        end else if (pe_tx_valid && can_load) begin
            st_d.ovalid = 1'b1;
            st_d.oflit  = {(pe_tx_last ? KIND_TAIL : KIND_BODY), pe_tx_data};
            if (pe_tx_last) begin
                st_d.phase = TX_HEAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: TX_HEAD, ovalid: 1'b0, oflit: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rt_out_valid = st_q.ovalid;
    assign rt_out_flit  = st_q.oflit;

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_out_valid && !rt_out_ready |=> rt_out_valid && $stable(rt_out_flit));

    // R4
    tx_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_tx_valid && pe_tx_ready && pe_tx_last |=>
            rt_out_valid && rt_out_flit[FLIT_W-1:FLIT_W-2] == KIND_TAIL);

    // R3
    tx_new_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_tx_valid && pe_tx_ready && pe_tx_last |=> !pe_tx_ready);

    // R3
    tx_body_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_tx_valid && pe_tx_ready |=> !rt_out_flit[FLIT_W-1]);
endmodule

// File: rtl/ni_rx_unpacker.sv
module ni_rx_unpacker
    import ni_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_in_valid,
    output logic              rt_in_ready,
    input  logic [DATA_W+1:0] rt_in_flit,
    output logic              pe_rx_valid,
    input  logic              pe_rx_ready,
    output logic [DATA_W-1:0] pe_rx_data,
    output logic              pe_rx_last
);
    localparam int FLIT_W = DATA_W + 2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
    } rx_state_t;

    rx_state_t  st_d, st_q;
    logic [1:0] kind;

    always_comb begin
        st_d        = st_q;
        kind        = rt_in_flit[FLIT_W-1:FLIT_W-2];
        rt_in_ready = !st_q.valid || pe_rx_ready;
        if (st_q.valid && pe_rx_ready) begin
            st_d.valid = 1'b0;
        end
        if (rt_in_valid && rt_in_ready && !kind[1]) begin
            st_d.valid = 1'b1;
            st_d.data  = rt_in_flit[DATA_W-1:0];
            st_d.last  = (kind == KIND_TAIL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pe_rx_valid = st_q.valid;
    assign pe_rx_data  = st_q.data;
    assign pe_rx_last  = st_q.last;

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_rx_valid && !pe_rx_ready |=>
            pe_rx_valid && $stable(pe_rx_data) && $stable(pe_rx_last));

    // R6
    rx_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_in_valid && rt_in_ready && rt_in_flit[FLIT_W-1] && (!pe_rx_valid || pe_rx_ready)
            |=> !pe_rx_valid);
endmodule

// File: rtl/ni_wrapper.sv
module ni_wrapper #(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pe_tx_valid,
    output logic               pe_tx_ready,
    input  logic [DATA_W-1:0]  pe_tx_data,
    input  logic               pe_tx_last,
    input  logic [COORD_W-1:0] pe_tx_dst_x,
    input  logic [COORD_W-1:0] pe_tx_dst_y,
    output logic               rt_out_valid,
    input  logic               rt_out_ready,
    output logic [DATA_W+1:0]  rt_out_flit,
    input  logic               rt_in_valid,
    output logic               rt_in_ready,
    input  logic [DATA_W+1:0]  rt_in_flit,
    output logic               pe_rx_valid,
    input  logic               pe_rx_ready,
    output logic [DATA_W-1:0]  pe_rx_data,
    output logic               pe_rx_last
);
    ni_tx_packer #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pe_tx_valid (pe_tx_valid),
        .pe_tx_ready (pe_tx_ready),
        .pe_tx_data  (pe_tx_data),
        .pe_tx_last  (pe_tx_last),
        .pe_tx_dst_x (pe_tx_dst_x),
        .pe_tx_dst_y (pe_tx_dst_y),
        .rt_out_valid(rt_out_valid),
        .rt_out_ready(rt_out_ready),
        .rt_out_flit (rt_out_flit)
    );

    ni_rx_unpacker #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rt_in_valid(rt_in_valid),
        .rt_in_ready(rt_in_ready),
        .rt_in_flit (rt_in_flit),
        .pe_rx_valid(pe_rx_valid),
        .pe_rx_ready(pe_rx_ready),
        .pe_rx_data (pe_rx_data),
        .pe_rx_last (pe_rx_last)
    );
endmodule

// File: tb/ni_wrapper_bench.sv
module ni_wrapper_bench;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pe_tx_valid = 1'b0, pe_tx_last = 1'b0;
    logic [DW-1:0] pe_tx_data = '0;
    logic [CW-1:0] pe_tx_dst_x = '0, pe_tx_dst_y = '0;
    logic          pe_tx_ready, rt_out_valid;
    logic          rt_out_ready = 1'b1;
    logic [FW-1:0] rt_out_flit;
    logic          rt_in_valid = 1'b0;
    logic [FW-1:0] rt_in_flit = '0;
    logic          rt_in_ready, pe_rx_valid, pe_rx_last;
    logic          pe_rx_ready = 1'b1;
    logic [DW-1:0] pe_rx_data;

    int checks = 0, errors = 0, cycles = 0;
    int tx_mode = 0, rx_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [FW-1:0] txq[$], txexp[$];
    logic [DW:0]   rxq[$], rxexp[$];
    logic          stall_prev = 1'b0;
    logic [FW-1:0] flit_prev = '0;

    always #4 clk = ~clk;

    ni_wrapper #(.DATA_W(DW), .COORD_W(CW)) u_ni_wrapper (
        .clk(clk), .rst_n(rst_n),
        .pe_tx_valid(pe_tx_valid), .pe_tx_ready(pe_tx_ready), .pe_tx_data(pe_tx_data),
        .pe_tx_last(pe_tx_last), .pe_tx_dst_x(pe_tx_dst_x), .pe_tx_dst_y(pe_tx_dst_y),
        .rt_out_valid(rt_out_valid), .rt_out_ready(rt_out_ready), .rt_out_flit(rt_out_flit),
        .rt_in_valid(rt_in_valid), .rt_in_ready(rt_in_ready), .rt_in_flit(rt_in_flit),
        .pe_rx_valid(pe_rx_valid), .pe_rx_ready(pe_rx_ready), .pe_rx_data(pe_rx_data),
        .pe_rx_last(pe_rx_last)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] head_flit(input logic [CW-1:0] x, input logic [CW-1:0] y);
        return {2'b10, {(DW-2*CW){1'b0}}, y, x};
    endfunction

    // ready generators and monitors, all acting at the rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rt_out_ready <= (tx_mode == 0) ? 1'b1 : lfsr[3];
        pe_rx_ready  <= (rx_mode == 0) ? 1'b1 : (rx_mode == 1) ? lfsr[7] : 1'b0;
        if (rst_n) begin
            if (stall_prev) begin
                // R5: stalled flit must stay put
                check(rt_out_valid && rt_out_flit == flit_prev, "R5",
                      {29'b0, rt_out_valid, rt_out_flit}, {29'b0, 1'b1, flit_prev});
            end
            stall_prev <= rt_out_valid && !rt_out_ready;
            flit_prev  <= rt_out_flit;
            if (rt_out_valid && rt_out_ready) txq.push_back(rt_out_flit);
            if (pe_rx_valid && pe_rx_ready) rxq.push_back({pe_rx_last, pe_rx_data});
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tx_packet(input logic [CW-1:0] x, input logic [CW-1:0] y,
                             input int n, input logic [DW-1:0] base);
        txexp.push_back(head_flit(x, y));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pe_tx_valid = 1'b1; pe_tx_dst_x = x; pe_tx_dst_y = y;
            pe_tx_data  = base + DW'(i * 3);
            pe_tx_last  = (i == n - 1);
            txexp.push_back({(i == n - 1) ? 2'b01 : 2'b00, base + DW'(i * 3)});
            do @(posedge clk); while (!pe_tx_ready);
        end
        @(negedge clk);
        pe_tx_valid = 1'b0;
    endtask

    task automatic tx_compare(input string scen);
        int guard = 0;
        while (txq.size() < txexp.size() && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
        check(txq.size() == txexp.size(), "R4 count", 64'(txq.size()), 64'(txexp.size()));
        for (int i = 0; i < txexp.size() && i < txq.size(); i++) begin
            string tag;
            if (txexp[i][FW-1]) tag = (i == 0) ? "R3 header first" : "R9 header coord";
            else if (txexp[i][FW-2]) tag = "R4 tail";
            else tag = "R2 data flit";
            check(txq[i] == txexp[i], {scen, " ", tag}, 64'(txq[i]), 64'(txexp[i]));
        end
        txq.delete(); txexp.delete();
    endtask

    task automatic rx_flit(input logic [FW-1:0] f);
        @(negedge clk);
        rt_in_valid = 1'b1; rt_in_flit = f;
        if (!f[FW-1]) rxexp.push_back({f[FW-2], f[DW-1:0]});
        do @(posedge clk); while (!rt_in_ready);
        @(negedge clk);
        rt_in_valid = 1'b0;
    endtask

    task automatic rx_compare(input string scen);
        int guard = 0;
        while (rxq.size() < rxexp.size() && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
        check(rxq.size() == rxexp.size(), "R6 count", 64'(rxq.size()), 64'(rxexp.size()));
        for (int i = 0; i < rxexp.size() && i < rxq.size(); i++)
            check(rxq[i] == rxexp[i], {scen, " R7 word"}, 64'(rxq[i]), 64'(rxexp[i]));
        rxq.delete(); rxexp.delete();
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!rt_out_valid, "R1 rt_out_valid", 64'(rt_out_valid), 0);
        check(!pe_rx_valid, "R1 pe_rx_valid", 64'(pe_rx_valid), 0);
        check(!pe_tx_ready, "R1 pe_tx_ready", 64'(pe_tx_ready), 0);
        check(rt_in_ready, "R1 rt_in_ready", 64'(rt_in_ready), 1);
    endtask

    task automatic test_tx_free();
        tx_mode = 0;
        tx_packet(4'd3, 4'd5, 3, 32'h1000_0000);
        tx_packet(4'd0, 4'd15, 1, 32'hDEAD_BEEF);
        tx_compare("tx free");
    endtask

    task automatic test_tx_backpressure();
        tx_mode = 1;
        tx_packet(4'd7, 4'd1, 5, 32'hA500_0000);
        tx_packet(4'd2, 4'd9, 2, 32'h0000_0011);
        tx_packet(4'd15, 4'd0, 4, 32'hFFFF_FFF0);
        tx_compare("tx stall");
        tx_mode = 0;
    endtask

    task automatic test_rx_free();
        rx_mode = 0;
        rx_flit(head_flit(4'd1, 4'd2));
        rx_flit({2'b00, 32'h0000_0AAA});
        rx_flit({2'b01, 32'h0000_0BBB});
        rx_flit(head_flit(4'd9, 4'd9));
        rx_flit({2'b01, 32'h1234_5678});
        rx_compare("rx free");
    endtask

    task automatic test_rx_backpressure();
        rx_mode = 1;
        rx_flit(head_flit(4'd4, 4'd4));
        for (int i = 0; i < 6; i++) rx_flit({(i == 5) ? 2'b01 : 2'b00, 32'hC000_0000 + i});
        rx_flit(head_flit(4'd5, 4'd6));
        rx_flit({2'b01, 32'h7777_7777});
        rx_compare("rx stall");
        rx_mode = 0;
    endtask

    task automatic test_rx_hold();
        rx_mode = 2;
        repeat (2) @(negedge clk);
        rt_in_valid = 1'b1; rt_in_flit = {2'b00, 32'h0000_00A1};
        rxexp.push_back({1'b0, 32'h0000_00A1});
        do @(posedge clk); while (!rt_in_ready);
        @(negedge clk);
        rt_in_flit = {2'b01, 32'h0000_00B2};
        rxexp.push_back({1'b1, 32'h0000_00B2});
        repeat (3) @(negedge clk);
        // R8: word held and router side blocked
        check(!rt_in_ready, "R8 rt_in_ready", 64'(rt_in_ready), 0);
        check(pe_rx_valid && pe_rx_data == 32'h0000_00A1, "R8 held word",
              {31'b0, pe_rx_valid, pe_rx_data}, {31'b0, 1'b1, 32'h0000_00A1});
        rx_mode = 0;
        do @(posedge clk); while (!rt_in_ready);
        @(negedge clk);
        rt_in_valid = 1'b0;
        rx_compare("rx hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_tx_free();
        test_tx_backpressure();
        test_rx_free();
        test_rx_backpressure();
        test_rx_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule